// File: doc/BRIEF.md
# Two-Lane Interleaved Sample Serializer

This block is the transmit side of a fast converter's serial data link. It takes parallel 12-bit samples, at most one per word period, and sends each one over two serial lanes. One lane carries the odd-weighted bits and the other the even-weighted bits, most significant first, and both lanes move in the same bit slots. Alongside the lanes it drives a frame marker and a bit enable that shows which slots hold a real sample. The model uses one fast clock, and each clock cycle is one serial bit slot.

A static format input picks the word length. The wide format sends 8 slots per lane per sample: six data bits, an overrange flag and a zero pad. The narrow format drops the pad and sends 7 slots. In the narrow format the frame marker covers two samples. A sample offered during a word period appears on the lanes six word periods later. The format input may change only while reset is held.

Top module: `dual_lane_serializer`

## Requirements
- R1: While reset is low, after one clock edge, both lanes and bit_en are 0 and frame is 1.
- R2: Slots 0 to 5 of a word carry sample bits 11, 9, 7, 5, 3, 1 on lane_a, in that order.
- R3: Slots 0 to 5 of a word carry sample bits 10, 8, 6, 4, 2, 0 on lane_b, in that order.
- R4: Slot 6 carries the sample's overrange flag on both lanes: 1 if smp_ovr was high with the sample, 0 otherwise.
- R5: With fmt_sel=0 (wide) a word is 8 slots, and slot 7 is 0 on both lanes.
- R6: With fmt_sel=1 (narrow) a word is 7 slots and the next word starts right after slot 6.
- R7: With fmt_sel=0, frame is 1 in slots 0 to 3 and 0 in slots 4 to 7 of every word.
- R8: With fmt_sel=1, frame is 1 for all of the even-numbered words and 0 for all of the odd-numbered words. Words are numbered from 0, starting at reset release.
- R9: Word periods are numbered from reset release. Word 0 starts in the first cycle after reset goes high. A sample is presented with smp_valid during word P, and if several are presented the last one is used. That sample is sent in word P+6.
- R10: bit_en is 1 for every slot of a word that carries a sample. It is 0, with both lanes 0, for a word whose source period had no smp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 1 | Word format: 0 = 8 slots per word, 1 = 7 slots per word |
| smp_valid | input | 1 | Strobe: smp_data and smp_ovr hold a new sample |
| smp_data | input | 12 | Parallel sample |
| smp_ovr | input | 1 | Overrange flag for the sample |
| lane_a | output | 1 | Serial lane carrying the odd-weighted bits |
| lane_b | output | 1 | Serial lane carrying the even-weighted bits |
| frame | output | 1 | Frame marker |
| bit_en | output | 1 | High while the current slot carries a sample |

## Verification
The hardest case to reach from the ports is a sample strobe that lands in the last slot of a word. In that cycle the holding stage is emptied into the delay line, so the arriving sample must skip the holding register and go straight into the first delay stage. The directed streams place strobes at chosen slot offsets in each word, including that final slot in both formats. They also include a word where a junk sample is later overwritten, and an empty word. Because every slot of the six-word-delayed output is compared, any mistake in alignment, ordering or pair phase shows up.

// File: rtl/ser_pkg.sv
// Shared definitions for the two-lane sample serializer.
// Assumes nothing beyond a 1-bit word-format selector.
package ser_pkg;

    // Word format: wide words end with a zero pad slot, narrow words do not.
    typedef enum logic {
        FMT_WIDE   = 1'b0,
        FMT_NARROW = 1'b1
    } fmt_e;

endpackage

// File: rtl/ser_slot_timer.sv
// Slot timer: counts bit slots inside a word, flags the last slot, tracks
// the even/odd word phase and derives the frame marker from both.
// Assumes fmt only changes while rst_n is low.
module ser_slot_timer
    import ser_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CNT_W  = $clog2(DATA_W / 2 + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_e             fmt,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             frame
);
    localparam int SLOTS_WIDE   = DATA_W / 2 + 2;
    localparam int SLOTS_NARROW = DATA_W / 2 + 1;
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(SLOTS_WIDE - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(SLOTS_NARROW - 1);
    localparam logic [CNT_W-1:0] HALF_WIDE   = CNT_W'(SLOTS_WIDE / 2);

    logic             odd_word;
    logic [CNT_W-1:0] last_slot;

    // Last slot index of the selected format.
    always_comb last_slot = (fmt == FMT_NARROW) ? LAST_NARROW : LAST_WIDE;

    assign wrap = (cnt == last_slot);

    // Slot counter and word-phase flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            odd_word <= 1'b0;
        end else if (wrap) begin
            cnt      <= '0;
            odd_word <= ~odd_word;
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end

    // Frame marker: half-word in wide format, whole word pairs in narrow.
    always_comb frame = (fmt == FMT_NARROW) ? ~odd_word : (cnt < HALF_WIDE);

    // R6: slot counter never passes the selected word length
    a_r6_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_slot);

    // R8: in narrow format the marker only moves across a word boundary
    a_r8_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_NARROW && !$past(wrap)) |-> $stable(frame));

    // R7: in wide format the marker drops exactly at the half-word slot
    a_r7_frame_half: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_WIDE && $fell(frame)) |-> cnt == HALF_WIDE);

endmodule

// File: rtl/ser_sample_pipe.sv
// Sample pipe: holds the latest sample offered in the current word and moves
// it one stage per word period through a delay line of DEPTH stages.
// Entry layout is {valid, ovr, data}. A strobe in the shift cycle goes
// straight into the first stage. Assumes DEPTH >= 1.
module ser_sample_pipe #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 5,
    parameter int EW     = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_ovr,
    output logic [EW-1:0]     out_entry
);
    logic [EW-1:0] hold;
    logic [EW-1:0] next_entry;
    logic [EW-1:0] stg [DEPTH];

    // Entry entering the delay line at a word boundary.
    always_comb next_entry = in_valid ? {1'b1, in_ovr, in_data} : hold;

    // Holding register: last strobe wins, emptied at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold <= '0;
        else if (shift)    hold <= '0;
        else if (in_valid) hold <= {1'b1, in_ovr, in_data};
    end

    // First delay stage takes the word's sample at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)     stg[0] <= '0;
        else if (shift) stg[0] <= next_entry;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        // Later delay stage advances one word per boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)     stg[i] <= '0;
            else if (shift) stg[i] <= stg[i-1];
        end
    end

    assign out_entry = stg[DEPTH-1];

    // R9: delay line output only moves at a word boundary
    a_r9_pipe_still: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(shift) |-> $stable(out_entry));

    // R9: a strobe in the boundary cycle lands in the first stage
    a_r9_boundary_take: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && in_valid) |=> stg[0] == {1'b1, $past(in_ovr), $past(in_data)});

endmodule

// File: rtl/ser_lane_mux.sv
// Lane multiplexer: latches the outgoing word at each boundary and picks,
// per slot, the odd/even data bit pair, the overrange flag or the pad.
// Assumes the slot counter restarts at 0 the cycle after load.
module ser_lane_mux
    import ser_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CNT_W  = $clog2(DATA_W / 2 + 2),
    parameter int EW     = DATA_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [EW-1:0]    entry,
    input  logic [CNT_W-1:0] cnt,
    input  fmt_e             fmt,
    output logic             lane_a,
    output logic             lane_b,
    output logic             live
);
    localparam int PAIRS = DATA_W / 2;
    localparam logic [CNT_W-1:0] FLAG_SLOT = CNT_W'(PAIRS);
    localparam logic [CNT_W-1:0] PAD_SLOT  = CNT_W'(PAIRS + 1);

    logic [EW-1:0]     word_q;
    logic [DATA_W-1:0] shifted;

    // Outgoing word register, refreshed at every boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= entry;
    end

    // Align the current bit pair to the top of the data field.
    always_comb shifted = word_q[DATA_W-1:0] << {cnt, 1'b0};

    // Slot content selection.
    always_comb begin
        live   = word_q[EW-1];
        lane_a = 1'b0;
        lane_b = 1'b0;
        if (live) begin
            if (cnt < FLAG_SLOT) begin
                lane_a = shifted[DATA_W-1];
                lane_b = shifted[DATA_W-2];
            end else if (cnt == FLAG_SLOT) begin
                lane_a = word_q[DATA_W];
                lane_b = word_q[DATA_W];
            end
        end
    end

    // R5: pad slot of a wide word is zero on both lanes
    a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_WIDE && cnt == PAD_SLOT) |-> (!lane_a && !lane_b));

    // R4: both lanes agree in the flag slot
    a_r4_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FLAG_SLOT) |-> (lane_a == lane_b));

    // R10: an empty word keeps both lanes quiet
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> (!lane_a && !lane_b));

endmodule

// File: rtl/dual_lane_serializer.sv
// Two-lane interleaved sample serializer top. Splits each sample into odd
// and even bit lanes, adds an overrange flag slot and, in wide format, a
// pad slot, and drives a frame marker. Output lags input by LATENCY words.
// Assumes fmt_sel is static outside reset and LATENCY >= 2.
module dual_lane_serializer
    import ser_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int LATENCY = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_sel,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_ovr,
    output logic              lane_a,
    output logic              lane_b,
    output logic              frame,
    output logic              bit_en
);
    localparam int CNT_W = $clog2(DATA_W / 2 + 2);
    localparam int EW    = DATA_W + 2;
    localparam int DEPTH = LATENCY - 1;

    fmt_e             fmt;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [EW-1:0]    pipe_out;

    assign fmt = fmt_e'(fmt_sel);

    ser_slot_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .fmt   (fmt),
        .cnt   (cnt),
        .wrap  (wrap),
        .frame (frame)
    );

    ser_sample_pipe #(.DATA_W(DATA_W), .DEPTH(DEPTH), .EW(EW)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift     (wrap),
        .in_valid  (smp_valid),
        .in_data   (smp_data),
        .in_ovr    (smp_ovr),
        .out_entry (pipe_out)
    );

    ser_lane_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W), .EW(EW)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wrap),
        .entry  (pipe_out),
        .cnt    (cnt),
        .fmt    (fmt),
        .lane_a (lane_a),
        .lane_b (lane_b),
        .live   (bit_en)
    );

    // R1: one edge of reset leaves the outputs quiet with the marker high
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!lane_a && !lane_b && !bit_en && frame));

endmodule

// File: tb/dual_lane_serializer_tb.sv
`timescale 1ns/1ps
module dual_lane_serializer_tb;
    localparam int LAT = 6;
    localparam int MAXP = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fmt_sel = 1'b0;
    logic smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic smp_ovr = 1'b0;
    logic lane_a, lane_b, frame, bit_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Scenario description, one entry per word period.
    bit          has_s [MAXP];
    int          pslot [MAXP];
    bit          dup   [MAXP];
    logic [11:0] dval  [MAXP];
    bit          oval  [MAXP];

    always #2 clk = ~clk;

    dual_lane_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ovr(smp_ovr),
        .lane_a(lane_a), .lane_b(lane_b), .frame(frame), .bit_en(bit_en)
    );

    task automatic clear_plan();
        for (int i = 0; i < MAXP; i++) begin
            has_s[i] = 1'b0; pslot[i] = 1; dup[i] = 1'b0;
            dval[i] = '0; oval[i] = 1'b0;
        end
    endtask

    // Hold reset with the chosen format, check R1, release at a negedge.
    task automatic do_reset(input bit narrow);
        @(negedge clk);
        rst_n = 1'b0; fmt_sel = narrow; smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        total++;
        if (lane_a !== 1'b0 || lane_b !== 1'b0 || bit_en !== 1'b0 || frame !== 1'b1) begin
            bad++;
            $display("FAIL R1 reset state: actual a=%b b=%b en=%b fr=%b expected a=0 b=0 en=0 fr=1",
                     lane_a, lane_b, bit_en, frame);
        end
        rst_n = 1'b1;
    endtask

    // Drive the planned samples and compare every slot of np words (R2-R10).
    task automatic run_words(input bit narrow, input int np);
        int w;
        w = narrow ? 7 : 8;
        for (int t = 1; t < np * w; t++) begin
            int p, s, src;
            bit ea, eb, ef, ee;
            logic [11:0] d;
            string req;
            @(negedge clk);
            p = t / w; s = t % w; src = p - LAT;
            ea = 1'b0; eb = 1'b0; ee = 1'b0;
            if (src >= 0 && has_s[src]) begin
                ee = 1'b1; d = dval[src];
                if (s < 6) begin ea = d[11 - 2*s]; eb = d[10 - 2*s]; end
                else if (s == 6) begin ea = oval[src]; eb = oval[src]; end
            end
            ef = narrow ? (p % 2 == 0) : (s < 4);
            total++;
            if (lane_a !== ea || lane_b !== eb || frame !== ef || bit_en !== ee) begin
                bad++;
                if (bit_en !== ee) req = "R10 (R9 alignment)";
                else if (frame !== ef) req = narrow ? "R8" : "R7";
                else if (s < 6) req = narrow ? "R2 R3 R6" : "R2 R3";
                else if (s == 6) req = narrow ? "R4 R6" : "R4";
                else req = "R5";
                $display("FAIL %s word %0d slot %0d: actual a=%b b=%b fr=%b en=%b expected a=%b b=%b fr=%b en=%b",
                         req, p, s, lane_a, lane_b, frame, bit_en, ea, eb, ef, ee);
            end
            smp_valid = 1'b0;
            if (p < MAXP && has_s[p]) begin
                if (dup[p] && s == 1) begin
                    smp_valid = 1'b1; smp_data = 12'h3C3; smp_ovr = 1'b1;
                end else if (s == pslot[p]) begin
                    smp_valid = 1'b1; smp_data = dval[p]; smp_ovr = oval[p];
                end
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic plan(input int p, input logic [11:0] d, input bit o,
                        input int ps, input bit dp);
        has_s[p] = 1'b1; dval[p] = d; oval[p] = o; pslot[p] = ps; dup[p] = dp;
    endtask

    // Wide format: all-ones, alternating, MSB/LSB only, a gap word, a strobe in
    // the boundary slot (7) and an overwritten strobe (R2 R3 R4 R5 R7 R9 R10).
    task automatic t_wide_stream();
        clear_plan();
        plan(0, 12'hA5C, 1'b0, 1, 1'b0);
        plan(1, 12'hFFF, 1'b1, 3, 1'b0);
        plan(3, 12'h001, 1'b0, 7, 1'b0);
        plan(4, 12'h800, 1'b0, 5, 1'b1);
        plan(5, 12'h5A3, 1'b1, 2, 1'b0);
        plan(6, 12'h6D1, 1'b0, 4, 1'b0);
        plan(7, 12'h000, 1'b1, 6, 1'b0);
        do_reset(1'b0);
        run_words(1'b0, 14);
    endtask

    // Narrow format: 7-slot words, pair-phase marker, boundary slot 6 strobe
    // (R6 R8 R9 R4 R10).
    task automatic t_narrow_stream();
        clear_plan();
        plan(0, 12'h555, 1'b0, 2, 1'b0);
        plan(1, 12'hAAA, 1'b1, 6, 1'b0);
        plan(2, 12'h7E1, 1'b0, 4, 1'b1);
        plan(4, 12'hC3F, 1'b1, 1, 1'b0);
        plan(5, 12'h001, 1'b0, 6, 1'b0);
        plan(6, 12'h800, 1'b0, 3, 1'b0);
        do_reset(1'b1);
        run_words(1'b1, 13);
    endtask

    // Back to wide after narrow, through reset, with every word filled (R5 R7 R9).
    task automatic t_wide_after_narrow();
        clear_plan();
        for (int i = 0; i < 6; i++) plan(i, 12'(12'h123 * (i + 3)), i[0], 1 + i, 1'b0);
        do_reset(1'b0);
        run_words(1'b0, 12);
    endtask

    initial begin
        t_wide_stream();
        t_narrow_stream();
        t_wide_after_narrow();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual no completion expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule